// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control state of a small processor core: a status word with its backup copy and a second-level backup, a separate condition bit, two stack-pointer banks, two backup program counters, and two general-purpose control words. Software and the pipeline reach these registers by control-register number over one synchronous port. A read strobe captures a packed or masked view of the selected register into a registered read-data output. A write strobe splits the write word into the fields that the selected register keeps.

The block also owns the live stack pointer, which the general register file sees through the `sp_live` output and updates through a write port. The stack-mode bit of the status word selects which bank the live pointer stands for. When a status write flips that bit, the live pointer is saved into the bank of the mode being left and reloaded from the bank of the mode being entered, all in one clock edge. While a bank is the live one, its control-register number aliases the live pointer.

Top module: `cr_bank_file`

## Requirements
- R1: A synchronous active-high reset clears every register, the read-data output and the live stack pointer, and leaves the block in user stack mode.
- R2: Reading register 0 (status) returns the backup status field masked to bits {7,6,0} and placed at bits 15:8, ORed with the current status byte masked to bits 7:6, ORed with the condition bit in bit 0. All higher bits read zero.
- R3: Writing register 0 loads write bits 15:8 as the backup status field and bits 7:0 as the current status byte, and sets the condition bit from write bit 0.
- R4: Current-status bit 7 is the stack-mode bit (1 = system, 0 = user). A status write that changes it from 0 to 1 saves the live SP into the user bank and loads the live SP from the system bank in the same edge.
- R5: A status write that changes the stack-mode bit from 1 to 0 saves the live SP into the system bank and loads the live SP from the user bank. A status write that leaves the bit unchanged moves no stack pointer.
- R6: Register 2 is the system-stack bank and register 3 is the user-stack bank. Reading or writing the bank of the current mode accesses the live SP. Reading or writing the other bank accesses the stored copy.
- R7: Registers 6 and 7 (backup PCs) store 32 bits and read with bit 0 forced to zero. Register 8 (second backup status) keeps only write bits 7:0 and reads them masked to bits {7,6,0}.
- R8: Register 1 (condition) reads the condition bit in bit 0 and zero above it. A write to it changes only the condition bit, taken from write bit 0.
- R9: Registers 4 and 5 are plain full-width storage. Register numbers 9 to 15 read zero, and writes to them change no register.
- R10: The read data updates on the edge that samples the read strobe and holds while no read is requested. A read and a write in the same cycle return the value from before the write.
- R11: The SP write port loads the live SP. In a cycle where a control-port write also changes the live SP, the control-port write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_addr | input | AW | Control-register number for read and write |
| cr_wr_en | input | 1 | Write strobe |
| cr_wdata | input | DW | Write data |
| cr_rd_en | input | 1 | Read strobe |
| cr_rdata | output | DW | Registered read data |
| sp_wr_en | input | 1 | Live stack-pointer write strobe from the register file |
| sp_wdata | input | DW | Live stack-pointer write data |
| sp_live | output | DW | Live stack pointer |

## Verification
The assertions assume that the address is a defined value whenever a strobe is high, and that the data width is at least 16 bits so that the status fields fit. The swap properties relate the live pointer and the bank copies across one edge. They therefore assume that no reset lands between the status write and the following edge. The directed tasks drive every input on the falling edge with known values, release the strobes one cycle later, and assert reset only at the start of the run.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int CR_PSW    = 0;
  localparam int CR_COND   = 1;
  localparam int CR_SP_SYS = 2;
  localparam int CR_SP_USR = 3;
  localparam int CR_PLAIN0 = 4;
  localparam int CR_PLAIN1 = 5;
  localparam int CR_BPC    = 6;
  localparam int CR_BBPC   = 7;
  localparam int CR_BBPSW  = 8;
  localparam int CR_LAST   = 8;
  localparam int STORE_DEPTH = 4;
endpackage

// File: rtl/cr_status.sv
module cr_status #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_psw,
  input  logic          wr_cond,
  input  logic          wr_bbpsw,
  input  logic [2:0]    bpsw_wd,
  input  logic [1:0]    psw_wd,
  input  logic [2:0]    bbpsw_wd,
  input  logic          cond_wd,
  output logic          sm,
  output logic [DW-1:0] psw_view,
  output logic [DW-1:0] cond_view,
  output logic [DW-1:0] bbpsw_view
);
  logic [2:0] bpsw_q;
  logic [1:0] psw_q;
  logic [2:0] bbpsw_q;
  logic       cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bpsw_q  <= '0;
      psw_q   <= '0;
      bbpsw_q <= '0;
      cond_q  <= 1'b0;
    end else begin
      if (wr_psw) begin
        bpsw_q <= bpsw_wd;
        psw_q  <= psw_wd;
      end
      if (wr_psw || wr_cond) cond_q <= cond_wd;
      if (wr_bbpsw) bbpsw_q <= bbpsw_wd;
    end
  end

  assign sm = psw_q[1];

  always_comb begin
    psw_view        = '0;
    psw_view[15:14] = bpsw_q[2:1];
    psw_view[8]     = bpsw_q[0];
    psw_view[7:6]   = psw_q;
    psw_view[0]     = cond_q;
    cond_view       = '0;
    cond_view[0]    = cond_q;
    bbpsw_view      = '0;
    bbpsw_view[7:6] = bbpsw_q[2:1];
    bbpsw_view[0]   = bbpsw_q[0];
  end
endmodule

// File: rtl/cr_stack_bank.sv
module cr_stack_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sm,
  input  logic          wr_psw,
  input  logic          new_sm,
  input  logic          wr_sys,
  input  logic          wr_usr,
  input  logic [DW-1:0] wdata,
  input  logic          sp_we,
  input  logic [DW-1:0] sp_wd,
  output logic [DW-1:0] sp_q,
  output logic [DW-1:0] sys_q,
  output logic [DW-1:0] usr_q,
  output logic [DW-1:0] sys_view,
  output logic [DW-1:0] usr_view
);
  logic [DW-1:0] sp_n, sys_n, usr_n;

  always_comb begin
    sp_n  = sp_q;
    sys_n = sys_q;
    usr_n = usr_q;
    if (sp_we) sp_n = sp_wd;
    if (wr_psw && (new_sm != sm)) begin
      if (new_sm) begin
        usr_n = sp_q;
        sp_n  = sys_q;
      end else begin
        sys_n = sp_q;
        sp_n  = usr_q;
      end
    end else if (wr_sys) begin
      if (sm) sp_n = wdata;
      else    sys_n = wdata;
    end else if (wr_usr) begin
      if (!sm) sp_n = wdata;
      else     usr_n = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      sys_q <= '0;
      usr_q <= '0;
    end else begin
      sp_q  <= sp_n;
      sys_q <= sys_n;
      usr_q <= usr_n;
    end
  end

  assign sys_view = sm  ? sp_q : sys_q;
  assign usr_view = !sm ? sp_q : usr_q;
endmodule

// File: rtl/cr_word_store.sv
module cr_word_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rword
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) mem[g] <= '0;
      else if (we && (idx == IW'(g))) mem[g] <= wdata;
    end
  end

  assign rword = mem[idx];
endmodule

// File: rtl/cr_bank_file.sv
module cr_bank_file #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cr_addr,
  input  logic          cr_wr_en,
  input  logic [DW-1:0] cr_wdata,
  input  logic          cr_rd_en,
  output logic [DW-1:0] cr_rdata,
  input  logic          sp_wr_en,
  input  logic [DW-1:0] sp_wdata,
  output logic [DW-1:0] sp_live
);
  import cr_pkg::*;

  localparam int IW = $clog2(STORE_DEPTH);
  localparam logic [AW-1:0] A_PSW   = AW'(CR_PSW);
  localparam logic [AW-1:0] A_COND  = AW'(CR_COND);
  localparam logic [AW-1:0] A_SYS   = AW'(CR_SP_SYS);
  localparam logic [AW-1:0] A_USR   = AW'(CR_SP_USR);
  localparam logic [AW-1:0] A_P0    = AW'(CR_PLAIN0);
  localparam logic [AW-1:0] A_P1    = AW'(CR_PLAIN1);
  localparam logic [AW-1:0] A_BPC   = AW'(CR_BPC);
  localparam logic [AW-1:0] A_BBPC  = AW'(CR_BBPC);
  localparam logic [AW-1:0] A_BBPSW = AW'(CR_BBPSW);

  logic          sm;
  logic [DW-1:0] psw_view, cond_view, bbpsw_view;
  logic [DW-1:0] sys_bank, usr_bank, sys_view, usr_view;
  logic [DW-1:0] store_word, rd_view;
  logic          in_store;
  logic [IW-1:0] store_idx;

  assign in_store  = (cr_addr >= A_P0) && (cr_addr <= A_BBPC);
  assign store_idx = IW'(cr_addr - A_P0);

  cr_status #(.DW(DW)) u_status (
    .clk        (clk),
    .rst        (rst),
    .wr_psw     (cr_wr_en && (cr_addr == A_PSW)),
    .wr_cond    (cr_wr_en && (cr_addr == A_COND)),
    .wr_bbpsw   (cr_wr_en && (cr_addr == A_BBPSW)),
    .bpsw_wd    ({cr_wdata[15:14], cr_wdata[8]}),
    .psw_wd     (cr_wdata[7:6]),
    .bbpsw_wd   ({cr_wdata[7:6], cr_wdata[0]}),
    .cond_wd    (cr_wdata[0]),
    .sm         (sm),
    .psw_view   (psw_view),
    .cond_view  (cond_view),
    .bbpsw_view (bbpsw_view)
  );

  cr_stack_bank #(.DW(DW)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .sm       (sm),
    .wr_psw   (cr_wr_en && (cr_addr == A_PSW)),
    .new_sm   (cr_wdata[7]),
    .wr_sys   (cr_wr_en && (cr_addr == A_SYS)),
    .wr_usr   (cr_wr_en && (cr_addr == A_USR)),
    .wdata    (cr_wdata),
    .sp_we    (sp_wr_en),
    .sp_wd    (sp_wdata),
    .sp_q     (sp_live),
    .sys_q    (sys_bank),
    .usr_q    (usr_bank),
    .sys_view (sys_view),
    .usr_view (usr_view)
  );

  cr_word_store #(.DW(DW), .DEPTH(STORE_DEPTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (cr_wr_en && in_store),
    .idx   (store_idx),
    .wdata (cr_wdata),
    .rword (store_word)
  );

  always_comb begin
    rd_view = '0;
    case (cr_addr)
      A_PSW:          rd_view = psw_view;
      A_COND:         rd_view = cond_view;
      A_SYS:          rd_view = sys_view;
      A_USR:          rd_view = usr_view;
      A_P0, A_P1:     rd_view = store_word;
      A_BPC, A_BBPC:  rd_view = {store_word[DW-1:1], 1'b0};
      A_BBPSW:        rd_view = bbpsw_view;
      default:        rd_view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cr_rdata <= '0;
    else if (cr_rd_en) cr_rdata <= rd_view;
  end
endmodule

// File: rtl/cr_bank_file_chk.sv
module cr_bank_file_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] cr_addr,
  input logic          cr_wr_en,
  input logic [DW-1:0] cr_wdata,
  input logic          cr_rd_en,
  input logic [DW-1:0] cr_rdata,
  input logic [DW-1:0] sp_live,
  input logic          sm,
  input logic [DW-1:0] sys_bank,
  input logic [DW-1:0] usr_bank
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cr_rdata == '0 && sp_live == '0 && !sm)); // R1

  AST_SWAP_TO_SYS: assert property (@(posedge clk) disable iff (rst)
    (cr_wr_en && cr_addr == AW'(0) && cr_wdata[7] && !sm)
    |=> (sp_live == $past(sys_bank) && usr_bank == $past(sp_live) && sm)); // R4

  AST_SWAP_TO_USR: assert property (@(posedge clk) disable iff (rst)
    (cr_wr_en && cr_addr == AW'(0) && !cr_wdata[7] && sm)
    |=> (sp_live == $past(usr_bank) && sys_bank == $past(sp_live) && !sm)); // R5

  AST_LIVE_ALIAS_SYS: assert property (@(posedge clk) disable iff (rst)
    (cr_wr_en && cr_addr == AW'(2) && sm) |=> (sp_live == $past(cr_wdata))); // R6

  AST_BPC_EVEN: assert property (@(posedge clk) disable iff (rst)
    (cr_rd_en && (cr_addr == AW'(6) || cr_addr == AW'(7))) |=> !cr_rdata[0]); // R7

  AST_COND_NARROW: assert property (@(posedge clk) disable iff (rst)
    (cr_rd_en && cr_addr == AW'(1)) |=> (cr_rdata[DW-1:1] == '0)); // R8

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cr_rd_en && cr_addr > AW'(8)) |=> (cr_rdata == '0)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cr_rd_en |=> $stable(cr_rdata)); // R10
endmodule

bind cr_bank_file cr_bank_file_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cr_addr  (cr_addr),
  .cr_wr_en (cr_wr_en),
  .cr_wdata (cr_wdata),
  .cr_rd_en (cr_rd_en),
  .cr_rdata (cr_rdata),
  .sp_live  (sp_live),
  .sm       (sm),
  .sys_bank (sys_bank),
  .usr_bank (usr_bank)
);

// File: tb/cr_bank_file_test.sv
module cr_bank_file_test;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cr_addr = '0;
  logic          cr_wr_en = 1'b0;
  logic [DW-1:0] cr_wdata = '0;
  logic          cr_rd_en = 1'b0;
  logic [DW-1:0] cr_rdata;
  logic          sp_wr_en = 1'b0;
  logic [DW-1:0] sp_wdata = '0;
  logic [DW-1:0] sp_live;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cr_bank_file #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .cr_addr(cr_addr), .cr_wr_en(cr_wr_en),
    .cr_wdata(cr_wdata), .cr_rd_en(cr_rd_en), .cr_rdata(cr_rdata),
    .sp_wr_en(sp_wr_en), .sp_wdata(sp_wdata), .sp_live(sp_live)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic re, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic spwe, input logic [DW-1:0] spd);
    @(negedge clk);
    cr_wr_en = we; cr_rd_en = re; cr_addr = a; cr_wdata = d;
    sp_wr_en = spwe; sp_wdata = spd;
    @(negedge clk);
    cr_wr_en = 1'b0; cr_rd_en = 1'b0; sp_wr_en = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(1'b1, 1'b0, a, d, 1'b0, '0);
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    step(1'b0, 1'b1, a, '0, 1'b0, '0);
    check(req, cr_rdata, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) rd_check("R1 reset read", AW'(i), '0);
    check("R1 live sp", sp_live, '0);
  endtask

  task automatic t_cond;
    wr(4'd1, 32'hFFFF_FFFF);
    rd_check("R8 cond set", 4'd1, 32'h1);
    rd_check("R8 psw sees only cond", 4'd0, 32'h1);
    wr(4'd1, 32'hFFFF_FFFE);
    rd_check("R8 cond clear", 4'd1, 32'h0);
  endtask

  task automatic t_plain;
    wr(4'd4, 32'hDEAD_BEEF);
    wr(4'd5, 32'h1234_5678);
    rd_check("R9 plain4", 4'd4, 32'hDEAD_BEEF);
    rd_check("R9 plain5", 4'd5, 32'h1234_5678);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd_check("R9 unimpl 9", 4'd9, '0);
    rd_check("R9 unimpl 15", 4'd15, '0);
    rd_check("R9 plain4 untouched", 4'd4, 32'hDEAD_BEEF);
    rd_check("R9 psw untouched", 4'd0, '0);
    check("R9 sp untouched", sp_live, '0);
  endtask

  task automatic t_backup;
    wr(4'd6, 32'h1234_5679);
    rd_check("R7 bpc", 4'd6, 32'h1234_5678);
    wr(4'd7, 32'hFFFF_FFFF);
    rd_check("R7 bbpc", 4'd7, 32'hFFFF_FFFE);
    wr(4'd8, 32'hFFFF_FFFF);
    rd_check("R7 bbpsw mask", 4'd8, 32'h0000_00C1);
    wr(4'd8, 32'h0000_0100);
    rd_check("R7 bbpsw low byte", 4'd8, 32'h0);
  endtask

  task automatic t_stack;
    step(1'b0, 1'b0, '0, '0, 1'b1, 32'hAAAA_0000);
    check("R11 sp port", sp_live, 32'hAAAA_0000);
    wr(4'd2, 32'h1111_0000);
    check("R6 sys bank in user mode", sp_live, 32'hAAAA_0000);
    rd_check("R6 sys bank read", 4'd2, 32'h1111_0000);
    rd_check("R6 usr alias read", 4'd3, 32'hAAAA_0000);
    wr(4'd3, 32'hBBBB_0000);
    check("R6 usr alias write", sp_live, 32'hBBBB_0000);
    wr(4'd0, 32'h0000_0080);
    check("R4 swap to sys", sp_live, 32'h1111_0000);
    rd_check("R4 usr saved", 4'd3, 32'hBBBB_0000);
    rd_check("R6 sys alias read", 4'd2, 32'h1111_0000);
    wr(4'd2, 32'h2222_0000);
    check("R6 sys alias write", sp_live, 32'h2222_0000);
    wr(4'd0, 32'h0000_0080);
    check("R5 no swap on same mode", sp_live, 32'h2222_0000);
    wr(4'd0, 32'h0000_0000);
    check("R5 swap to user", sp_live, 32'hBBBB_0000);
    rd_check("R5 sys saved", 4'd2, 32'h2222_0000);
  endtask

  task automatic t_psw;
    wr(4'd0, 32'hFFFF_FF7F);
    rd_check("R2 psw pack", 4'd0, 32'h0000_C141);
    rd_check("R3 cond from psw", 4'd1, 32'h1);
    check("R3 user mode kept", sp_live, 32'hBBBB_0000);
    wr(4'd0, 32'h0000_3E3E);
    rd_check("R2 masked away", 4'd0, 32'h0);
    wr(4'd0, 32'h0000_41C1);
    rd_check("R3 split", 4'd0, 32'h0000_41C1);
    check("R4 swap via psw", sp_live, 32'h2222_0000);
    wr(4'd0, 32'h0);
    check("R5 back to user", sp_live, 32'hBBBB_0000);
  endtask

  task automatic t_read_timing;
    step(1'b1, 1'b1, 4'd4, 32'h0BAD_F00D, 1'b0, '0);
    check("R10 read before write", cr_rdata, 32'hDEAD_BEEF);
    wr(4'd5, 32'h7777_7777);
    check("R10 hold", cr_rdata, 32'hDEAD_BEEF);
    rd_check("R10 new value", 4'd4, 32'h0BAD_F00D);
  endtask

  task automatic t_sp_conflict;
    step(1'b1, 1'b0, 4'd3, 32'h6666_0000, 1'b1, 32'h5555_0000);
    check("R11 control wins", sp_live, 32'h6666_0000);
    step(1'b1, 1'b0, 4'd4, 32'h4444_4444, 1'b1, 32'h5555_0000);
    check("R11 sp port alongside other write", sp_live, 32'h5555_0000);
    step(1'b1, 1'b0, 4'd2, 32'h9999_0000, 1'b1, 32'h3333_0000);
    check("R11 banked write leaves port", sp_live, 32'h3333_0000);
    rd_check("R11 banked write stored", 4'd2, 32'h9999_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", cr_rdata, '0);
    rst = 1'b0;
    t_reset();
    t_cond();
    t_plain();
    t_backup();
    t_stack();
    t_psw();
    t_read_timing();
    t_sp_conflict();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule